// File: doc/BRIEF.md
# Flag-setting ALU

A combinational data-processing unit for a small load/store processor core. It takes two operands, an operation select, a set-flags control bit, the shifter's carry-out and the current status flags. It returns a result word and the next values of the status flags. The second operand is assumed to come already shifted. The register file, instruction decode, multiply and divide, memory access and condition evaluation all live outside this block.

The operation select is 4 bits wide:

| Code | Operation | Result |
|------|-----------|--------|
| 0 | add | A + B |
| 1 | subtract | A - B |
| 2 | reverse subtract | B - A |
| 3 | and | A & B |
| 4 | or | A \| B |
| 5 | exclusive or | A ^ B |
| 6 | bit clear | A & ~B |
| 7 | or-not | A \| ~B |
| 8 | move | B |
| 9 | move-not | ~B |

Codes 10 to 15 are unused.

The flag vector is packed as bit 3 = N (negative), bit 2 = Z (zero), bit 1 = C (carry / not-borrow) and bit 0 = V (overflow). The datapath width is a parameter and defaults to 32 bits.

Top module: `flagalu`

## Requirements
- R1: With opSel = 0 the result is opA + opB modulo 2^WIDTH. With setFlags = 1, C is the carry out of the top bit.
- R2: With opSel = 1 the result is opA - opB, and with opSel = 2 it is opB - opA. With setFlags = 1, C is 1 exactly when the unsigned minuend is greater than or equal to the subtrahend.
- R3: For codes 0, 1 and 2 with setFlags = 1, V is 1 exactly when the true signed result lies outside the signed WIDTH-bit range.
- R4: Codes 3, 4 and 5 give the bitwise and, or and exclusive or of opA and opB.
- R5: Code 6 gives opA & ~opB, and code 7 gives opA | ~opB.
- R6: Code 8 passes opB unchanged, and code 9 gives ~opB. With WIDTH = 32, an opB of 0x0000000F gives 0xFFFFFFF0.
- R7: For codes 0 to 9 with setFlags = 1, N equals the top result bit and Z is 1 exactly when the result is all zeros.
- R8: For codes 3 to 9 with setFlags = 1, C takes shiftCarry and V keeps its incoming value.
- R9: With setFlags = 0, flagsOut equals flagsIn while the result is still computed.
- R10: Codes 10 to 15 give a zero result and leave flagsOut equal to flagsIn whatever setFlags is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | first operand |
| opB | input | WIDTH | second operand, already shifted |
| opSel | input | 4 | operation code |
| setFlags | input | 1 | when 1, allows the flags to be updated |
| shiftCarry | input | 1 | carry out of the shifter |
| flagsIn | input | 4 | current {N,Z,C,V} |
| result | output | WIDTH | operation result |
| flagsOut | output | 4 | next {N,Z,C,V} |

## Verification
The overflow and carry corner cases are the hardest to reach from the ports. They appear only at the signed and unsigned wrap points, and on the reverse subtract they appear with the operand roles swapped. A 4-bit instance is swept over every opcode, every operand pair and both values of setFlags. This drives every wrap point, every equal-operand borrow case and every zero result for each operation. A 32-bit instance then takes directed vectors at the full-width boundaries.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_RSB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_BCLR = 4'd6,
    OP_ORN  = 4'd7,
    OP_MOVE = 4'd8,
    OP_MNOT = 4'd9
  } aluOp_e;

  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_OR   = 2'd1,
    FN_XOR  = 2'd2,
    FN_PASS = 2'd3
  } logicFn_e;

  typedef struct packed {
    logic     useAdder;
    logic     invA;
    logic     invB;
    logic     carryIn;
    logicFn_e logicFn;
    logic     writeFlags;
    logic     zeroResult;
  } aluCtrl_t;

endpackage

// File: rtl/flagalu_ctrl.sv
module flagalu_ctrl
  import flagalu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       setFlags,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.logicFn    = FN_AND;
    ctrl.writeFlags = setFlags;
    case (opSel)
      OP_ADD: ctrl.useAdder = 1'b1;
      OP_SUB: begin
        ctrl.useAdder = 1'b1;
        ctrl.invB     = 1'b1;
        ctrl.carryIn  = 1'b1;
      end
      OP_RSB: begin
        ctrl.useAdder = 1'b1;
        ctrl.invA     = 1'b1;
        ctrl.carryIn  = 1'b1;
      end
      OP_AND:  ctrl.logicFn = FN_AND;
      OP_OR:   ctrl.logicFn = FN_OR;
      OP_XOR:  ctrl.logicFn = FN_XOR;
      OP_BCLR: begin
        ctrl.logicFn = FN_AND;
        ctrl.invB    = 1'b1;
      end
      OP_ORN: begin
        ctrl.logicFn = FN_OR;
        ctrl.invB    = 1'b1;
      end
      OP_MOVE: ctrl.logicFn = FN_PASS;
      OP_MNOT: begin
        ctrl.logicFn = FN_PASS;
        ctrl.invB    = 1'b1;
      end
      default: begin
        ctrl.zeroResult = 1'b1;
        ctrl.writeFlags = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flagalu_datapath.sv
module flagalu_datapath
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  input  logic             shiftCarry,
  input  logic [3:0]       flagsIn,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] aOp;
  logic [WIDTH-1:0] bOp;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             vArith;
  logic [WIDTH-1:0] logicRes;

  assign aOp      = ctrl.invA ? ~opA : opA;
  assign bOp      = ctrl.invB ? ~opB : opB;
  assign sumWide  = {1'b0, aOp} + {1'b0, bOp} + {{WIDTH{1'b0}}, ctrl.carryIn};
  assign sum      = sumWide[MSB:0];
  assign carryOut = sumWide[WIDTH];
  assign vArith   = (aOp[MSB] == bOp[MSB]) && (sum[MSB] != aOp[MSB]);

  always_comb begin
    case (ctrl.logicFn)
      FN_AND:  logicRes = opA & bOp;
      FN_OR:   logicRes = opA | bOp;
      FN_XOR:  logicRes = opA ^ bOp;
      default: logicRes = bOp;
    endcase
  end

  always_comb begin
    if (ctrl.zeroResult)    result = '0;
    else if (ctrl.useAdder) result = sum;
    else                    result = logicRes;
  end

  always_comb begin
    flagsOut = flagsIn;
    if (ctrl.writeFlags) begin
      flagsOut[3] = result[MSB];
      flagsOut[2] = (result == '0);
      flagsOut[1] = ctrl.useAdder ? carryOut : shiftCarry;
      flagsOut[0] = ctrl.useAdder ? vArith : flagsIn[0];
    end
  end

  // R1: plain add must match the operand sum
  always_comb begin
    if (ctrl.useAdder && !ctrl.invA && !ctrl.invB && !ctrl.zeroResult)
      assert_add_sum_R1: assert (result == WIDTH'(opA + opB))
        else $error("add result mismatch");
  end

endmodule

// File: rtl/flagalu.sv
module flagalu
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  input  logic             setFlags,
  input  logic             shiftCarry,
  input  logic [3:0]       flagsIn,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsOut
);

  aluCtrl_t ctrl;

  flagalu_ctrl u_ctrl (
    .opSel    (opSel),
    .setFlags (setFlags),
    .ctrl     (ctrl)
  );

  flagalu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA        (opA),
    .opB        (opB),
    .ctrl       (ctrl),
    .shiftCarry (shiftCarry),
    .flagsIn    (flagsIn),
    .result     (result),
    .flagsOut   (flagsOut)
  );

  always_comb begin
    if (!setFlags)
      assert_flags_hold_R9: assert (flagsOut == flagsIn)
        else $error("flags changed without setFlags");
    if (opSel > 4'd9)
      assert_unused_zero_R10: assert (result == '0 && flagsOut == flagsIn)
        else $error("unused code misbehaved");
    if (setFlags && opSel <= 4'd9)
      assert_zero_flag_R7: assert (flagsOut[2] == (result == '0) && flagsOut[3] == result[WIDTH-1])
        else $error("N/Z mismatch");
    if (setFlags && opSel >= 4'd3 && opSel <= 4'd9)
      assert_logic_cv_R8: assert (flagsOut[1] == shiftCarry && flagsOut[0] == flagsIn[0])
        else $error("logical C/V mismatch");
    if (setFlags && opSel == 4'd1)
      assert_sub_carry_R2: assert (flagsOut[1] == (opA >= opB))
        else $error("subtract carry mismatch");
  end

endmodule

// File: tb/flagalu_tb.sv
module flagalu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [SW-1:0] sA, sB, sRes;
  logic [3:0]    sOp, sFin, sFout;
  logic          sSf, sSc;
  logic [LW-1:0] lA, lB, lRes;
  logic [3:0]    lOp, lFin, lFout;
  logic          lSf, lSc;

  flagalu #(.WIDTH(SW)) u_dut (
    .opA(sA), .opB(sB), .opSel(sOp), .setFlags(sSf), .shiftCarry(sSc),
    .flagsIn(sFin), .result(sRes), .flagsOut(sFout)
  );

  flagalu #(.WIDTH(LW)) u_dut_wide (
    .opA(lA), .opB(lB), .opSel(lOp), .setFlags(lSf), .shiftCarry(lSc),
    .flagsIn(lFin), .result(lRes), .flagsOut(lFout)
  );

  function automatic longint toSigned(longint x, int w);
    return x[w-1] ? x - (longint'(1) << w) : x;
  endfunction

  task automatic model(input int w, input int op, input longint a, input longint b,
                       input bit sf, input bit sc, input logic [3:0] fin,
                       output longint res, output logic [3:0] fl);
    longint mask = (longint'(1) << w) - 1;
    longint full;
    longint sv;
    bit arith = 1'b0;
    bit c = 1'b0;
    bit v = 1'b0;
    case (op)
      0: begin full = a + b; res = full & mask; c = full[w]; sv = toSigned(a, w) + toSigned(b, w); arith = 1'b1; end
      1: begin res = (a - b) & mask; c = (a >= b); sv = toSigned(a, w) - toSigned(b, w); arith = 1'b1; end
      2: begin res = (b - a) & mask; c = (b >= a); sv = toSigned(b, w) - toSigned(a, w); arith = 1'b1; end
      3: res = a & b;
      4: res = a | b;
      5: res = a ^ b;
      6: res = a & (~b & mask);
      7: res = (a | (~b & mask)) & mask;
      8: res = b;
      9: res = ~b & mask;
      default: res = 0;
    endcase
    if (arith) v = (sv > (mask >> 1)) || (sv < -((mask >> 1) + 1));
    fl = fin;
    if (sf && op <= 9) begin
      fl[3] = res[w-1];
      fl[2] = (res == 0);
      fl[1] = arith ? c : sc;
      fl[0] = arith ? v : fin[0];
    end
  endtask

  function automatic string resTag(int op);
    if (op <= 2) return (op == 0) ? "R1" : "R2";
    if (op <= 5) return "R4";
    if (op <= 7) return "R5";
    if (op <= 9) return "R6";
    return "R10";
  endfunction

  function automatic string flagTag(int op, bit sf);
    if (op > 9) return "R10";
    if (!sf) return "R9";
    if (op <= 2) return "R1/R2/R3/R7";
    return "R7/R8";
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic runWide(int op, logic [31:0] a, logic [31:0] b, bit sf, bit sc, logic [3:0] fin);
    longint er;
    logic [3:0] ef;
    @(posedge clk);
    lOp = 4'(op); lA = a; lB = b; lSf = sf; lSc = sc; lFin = fin;
    @(negedge clk);
    model(LW, op, longint'(a), longint'(b), sf, sc, fin, er, ef);
    check(resTag(op), longint'(lRes), er);
    check(flagTag(op, sf), longint'(lFout), longint'(ef));
  endtask

  initial begin
    sA = '0; sB = '0; sOp = '0; sFin = '0; sSf = 1'b0; sSc = 1'b0;
    lA = '0; lB = '0; lOp = '0; lFin = '0; lSf = 1'b0; lSc = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset-state result", longint'(lRes), 0);
    check("R9 reset-state flags", longint'(lFout), 0);

    // exhaustive 4-bit sweep
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int sf = 0; sf < 2; sf++) begin
            longint er;
            logic [3:0] ef;
            logic [3:0] fin = 4'((a * 5 + b * 3 + op) & 15);
            bit sc = 1'(a ^ b ^ sf);
            @(posedge clk);
            sOp = 4'(op); sA = 4'(a); sB = 4'(b); sSf = 1'(sf); sSc = sc; sFin = fin;
            @(negedge clk);
            model(SW, op, longint'(a), longint'(b), 1'(sf), sc, fin, er, ef);
            check(resTag(op), longint'(sRes), er);
            check(flagTag(op, 1'(sf)), longint'(sFout), longint'(ef));
          end

    // 32-bit boundaries
    runWide(9, 32'h0000000F, 32'h0000000F, 1'b1, 1'b0, 4'b0000); // R6 move-not example
    runWide(0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b0, 4'b0000); // R3 signed overflow
    runWide(0, 32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b0, 4'b0000); // R1 carry, zero
    runWide(1, 32'h12345678, 32'h12345678, 1'b1, 1'b0, 4'b0000); // R2 equal, no borrow
    runWide(1, 32'h00000000, 32'h00000001, 1'b1, 1'b0, 4'b1111); // R2 borrow
    runWide(2, 32'h00000005, 32'h00000078, 1'b1, 1'b0, 4'b0000); // R2 reverse
    runWide(1, 32'h80000000, 32'h00000001, 1'b1, 1'b0, 4'b0000); // R3 sub overflow
    runWide(6, 32'hFFFF00FF, 32'h000000AB, 1'b1, 1'b1, 4'b0001); // R5 bit clear, R8
    runWide(7, 32'h0000F000, 32'hFFFFFFFF, 1'b1, 1'b0, 4'b0001); // R5 or-not
    runWide(8, 32'h0, 32'h0000FA05, 1'b0, 1'b1, 4'b1010);        // R6 move, R9 hold
    runWide(0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 4'b0110); // R9 hold on add
    runWide(12, 32'hDEADBEEF, 32'h1, 1'b1, 1'b1, 4'b0101);       // R10 unused code

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule